// File: doc/BRIEF.md
# Pin I/O controller with per-pin interrupt detection

This block is a 32-pin general-purpose I/O controller that sits on a simple 32-bit register bus with an address phase and an access phase. Software drives pins through an output data register, which it can overwrite whole or change bit by bit through separate set and clear registers. A direction register drives the per-pin output enables. Pin inputs are brought into the clock domain through a two-flop synchronizer and can be read back. Two further registers hold the pull enable and pull polarity for each pin. They are only stored and presented on output ports.

Each pin has its own trigger detector. Three per-pin configuration registers select the trigger: sense type (edge or level), polarity, and any-edge. A detected event on an enabled pin sets a latched pending bit. Software clears pending bits by writing ones. A pending bit drives the single interrupt line only when its pin is both enabled and unmasked. Software then reads the pending register to find which pins need service.

Top module: `pin_io_ctrl`

## Requirements
- R1: After reset every register reads zero, and pin_out, pin_oe, pull_en, pull_up and irq are all zero.
- R2: A write to the output register (offset 0x00) sets pin_out to the written value, and reading the same offset returns it. A write to the direction register (0x0C) drives pin_oe, where 1 enables the driver.
- R3: A write to the set register (0x04) forces 1 on each output bit written as 1. A write to the clear register (0x08) forces 0 on each bit written as 1. Bits written as 0 keep their value. pin_out changes only on writes to 0x00, 0x04 or 0x08.
- R4: The pin readback register (0x10) returns pin_in delayed by two clock edges.
- R5: With sense type 0 (edge, register 0x30), polarity 0 (register 0x34) and any-edge 0 (register 0x38), only a rising edge sets the pin's pending bit (register 0x28).
- R6: With edge sense, polarity 1 and any-edge 0, only a falling edge sets the pending bit.
- R7: With edge sense and any-edge 1, both edges set the pending bit, whatever the polarity bit holds.
- R8: With sense type 1 (level), polarity 0 means active high and polarity 1 means active low. The pending bit is set again on every cycle while the active level is held, so a clear only takes effect once the pin leaves that level.
- R9: A pending bit can be set only while its enable bit (register 0x20) is 1.
- R10: irq is 1 exactly when some pending bit has its enable bit at 1 and its mask bit (register 0x24) at 0. A mask bit of 1 hides the pin from irq without changing its pending bit.
- R11: Writing 1s to the interrupt clear register (0x2C) clears those pending bits and leaves the others. If a clear and a new event hit the same pin in the same cycle, the pending bit stays set.
- R12: The pull enable (0x14) and pull polarity (0x18) registers read back what was written and drive pull_en and pull_up. The write-only offsets (0x04, 0x08, 0x2C) read zero, and so does any unmapped offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus select |
| bus_en | input | 1 | Bus access phase |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_sel is high |
| pin_in | input | 32 | Pin inputs, asynchronous |
| pin_out | output | 32 | Output data |
| pin_oe | output | 32 | Output enables |
| pull_en | output | 32 | Stored pull enables |
| pull_up | output | 32 | Stored pull polarity, 1 = pull up |
| irq | output | 1 | Combined interrupt |

## Verification
If the synchronizer holds a wrong value, the pin readback register shows it two edges after the pin changes. A false edge caused by it reaches the pending register one edge later. If a trigger is decoded wrongly, the wrong pin's pending bit is set, or the right one is not, within three clock edges of the stimulus, and irq follows in the same cycle. If clear and event are given the wrong priority, or an enable or mask is handled wrongly, the fault shows at the next read of the pending register or on irq right after the relevant register write.

// File: rtl/pin_io_pkg.sv
package pin_io_pkg;
  localparam int unsigned BUS_W = 32;

  // Byte offsets of the register map
  localparam logic [7:0] OFS_OUT  = 8'h00;
  localparam logic [7:0] OFS_SET  = 8'h04;
  localparam logic [7:0] OFS_CLR  = 8'h08;
  localparam logic [7:0] OFS_DIR  = 8'h0C;
  localparam logic [7:0] OFS_PIN  = 8'h10;
  localparam logic [7:0] OFS_PEN  = 8'h14;
  localparam logic [7:0] OFS_PUP  = 8'h18;
  localparam logic [7:0] OFS_IEN  = 8'h20;
  localparam logic [7:0] OFS_IMSK = 8'h24;
  localparam logic [7:0] OFS_IPND = 8'h28;
  localparam logic [7:0] OFS_ICLR = 8'h2C;
  localparam logic [7:0] OFS_ITYP = 8'h30;
  localparam logic [7:0] OFS_IPOL = 8'h34;
  localparam logic [7:0] OFS_IBTH = 8'h38;

  typedef enum logic [1:0] {
    TRIG_RISE = 2'd0,
    TRIG_FALL = 2'd1,
    TRIG_ANY  = 2'd2,
    TRIG_LVL  = 2'd3
  } trig_kind_e;
endpackage

// File: rtl/pin_io_sync.sv
module pin_io_sync #(
  parameter int unsigned NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] cur,
  output logic [NPIN-1:0] prv
);
  logic [NPIN-1:0] meta_q, cur_q, prv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prv_q  <= '0;
    end else begin
      meta_q <= pin_in;
      cur_q  <= meta_q;
      prv_q  <= cur_q;
    end
  end

  assign cur = cur_q;
  assign prv = prv_q;
endmodule

// File: rtl/pin_io_detect.sv
module pin_io_detect
  import pin_io_pkg::*;
#(
  parameter int unsigned NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] cur,
  input  logic [NPIN-1:0] prv,
  input  logic [NPIN-1:0] sense_lvl,
  input  logic [NPIN-1:0] polarity,
  input  logic [NPIN-1:0] any_edge,
  input  logic [NPIN-1:0] enable,
  input  logic [NPIN-1:0] clr_bits,
  output logic [NPIN-1:0] pend
);
  logic [NPIN-1:0] hit;
  logic [NPIN-1:0] pend_d, pend_q;

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    trig_kind_e kind;
    logic rise, fall;

    always_comb begin
      rise = cur[g] & ~prv[g];
      fall = ~cur[g] & prv[g];
      if (sense_lvl[g])      kind = TRIG_LVL;
      else if (any_edge[g])  kind = TRIG_ANY;
      else if (polarity[g])  kind = TRIG_FALL;
      else                   kind = TRIG_RISE;
      unique case (kind)
        TRIG_RISE: hit[g] = rise;
        TRIG_FALL: hit[g] = fall;
        TRIG_ANY:  hit[g] = rise | fall;
        TRIG_LVL:  hit[g] = cur[g] ^ polarity[g];
        default:   hit[g] = 1'b0;
      endcase
    end
  end

  // A new event has priority over a clear in the same cycle
  always_comb begin
    pend_d = (pend_q & ~clr_bits) | (hit & enable);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;
endmodule

// File: rtl/pin_io_regs.sv
module pin_io_regs
  import pin_io_pkg::*;
#(
  parameter int unsigned NPIN = 32,
  parameter int unsigned AW   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_en,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic [NPIN-1:0]  pin_sync,
  input  logic [NPIN-1:0]  pend,
  output logic [NPIN-1:0]  out_q,
  output logic [NPIN-1:0]  dir_q,
  output logic [NPIN-1:0]  pen_q,
  output logic [NPIN-1:0]  pup_q,
  output logic [NPIN-1:0]  ien_q,
  output logic [NPIN-1:0]  imsk_q,
  output logic [NPIN-1:0]  ityp_q,
  output logic [NPIN-1:0]  ipol_q,
  output logic [NPIN-1:0]  ibth_q,
  output logic [NPIN-1:0]  clr_bits
);
  localparam int unsigned NOFS = 14;

  logic            wr_acc;
  logic [NPIN-1:0] wval;
  logic [NOFS-1:0] hit;
  logic            out_we;
  logic [NPIN-1:0] out_d;

  assign wr_acc = bus_sel & bus_en & bus_wr;
  assign wval   = bus_wdata[NPIN-1:0];

  always_comb begin
    hit[0]  = wr_acc && (bus_addr == AW'(OFS_OUT));
    hit[1]  = wr_acc && (bus_addr == AW'(OFS_SET));
    hit[2]  = wr_acc && (bus_addr == AW'(OFS_CLR));
    hit[3]  = wr_acc && (bus_addr == AW'(OFS_DIR));
    hit[4]  = wr_acc && (bus_addr == AW'(OFS_PEN));
    hit[5]  = wr_acc && (bus_addr == AW'(OFS_PUP));
    hit[6]  = wr_acc && (bus_addr == AW'(OFS_IEN));
    hit[7]  = wr_acc && (bus_addr == AW'(OFS_IMSK));
    hit[8]  = wr_acc && (bus_addr == AW'(OFS_ICLR));
    hit[9]  = wr_acc && (bus_addr == AW'(OFS_ITYP));
    hit[10] = wr_acc && (bus_addr == AW'(OFS_IPOL));
    hit[11] = wr_acc && (bus_addr == AW'(OFS_IBTH));
    hit[12] = 1'b0;
    hit[13] = 1'b0;
  end

  // Output data next state: direct, set or clear
  always_comb begin
    out_we = hit[0] | hit[1] | hit[2];
    out_d  = out_q;
    if (hit[0])      out_d = wval;
    else if (hit[1]) out_d = out_q | wval;
    else if (hit[2]) out_d = out_q & ~wval;
  end

  assign clr_bits = hit[8] ? wval : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      pen_q  <= '0;
      pup_q  <= '0;
      ien_q  <= '0;
      imsk_q <= '0;
      ityp_q <= '0;
      ipol_q <= '0;
      ibth_q <= '0;
    end else begin
      if (out_we)  out_q  <= out_d;
      if (hit[3])  dir_q  <= wval;
      if (hit[4])  pen_q  <= wval;
      if (hit[5])  pup_q  <= wval;
      if (hit[6])  ien_q  <= wval;
      if (hit[7])  imsk_q <= wval;
      if (hit[9])  ityp_q <= wval;
      if (hit[10]) ipol_q <= wval;
      if (hit[11]) ibth_q <= wval;
    end
  end

  // Read mux; write-only and unmapped offsets return zero
  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      unique case (bus_addr)
        AW'(OFS_OUT):  bus_rdata[NPIN-1:0] = out_q;
        AW'(OFS_DIR):  bus_rdata[NPIN-1:0] = dir_q;
        AW'(OFS_PIN):  bus_rdata[NPIN-1:0] = pin_sync;
        AW'(OFS_PEN):  bus_rdata[NPIN-1:0] = pen_q;
        AW'(OFS_PUP):  bus_rdata[NPIN-1:0] = pup_q;
        AW'(OFS_IEN):  bus_rdata[NPIN-1:0] = ien_q;
        AW'(OFS_IMSK): bus_rdata[NPIN-1:0] = imsk_q;
        AW'(OFS_IPND): bus_rdata[NPIN-1:0] = pend;
        AW'(OFS_ITYP): bus_rdata[NPIN-1:0] = ityp_q;
        AW'(OFS_IPOL): bus_rdata[NPIN-1:0] = ipol_q;
        AW'(OFS_IBTH): bus_rdata[NPIN-1:0] = ibth_q;
        default:       bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pin_io_ctrl.sv
module pin_io_ctrl
  import pin_io_pkg::*;
#(
  parameter int unsigned NPIN = 32,
  parameter int unsigned AW   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_en,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic [NPIN-1:0]  pin_in,
  output logic [NPIN-1:0]  pin_out,
  output logic [NPIN-1:0]  pin_oe,
  output logic [NPIN-1:0]  pull_en,
  output logic [NPIN-1:0]  pull_up,
  output logic             irq
);
  logic [1:0]      rst_pipe_q;
  logic            rst_sync_n;
  logic [NPIN-1:0] cur, prv, pend, clr_bits;
  logic [NPIN-1:0] ien, imsk, ityp, ipol, ibth;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  pin_io_sync #(.NPIN(NPIN)) i_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .pin_in (pin_in),
    .cur    (cur),
    .prv    (prv)
  );

  pin_io_regs #(.NPIN(NPIN), .AW(AW)) i_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_sel   (bus_sel),
    .bus_en    (bus_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_sync  (cur),
    .pend      (pend),
    .out_q     (pin_out),
    .dir_q     (pin_oe),
    .pen_q     (pull_en),
    .pup_q     (pull_up),
    .ien_q     (ien),
    .imsk_q    (imsk),
    .ityp_q    (ityp),
    .ipol_q    (ipol),
    .ibth_q    (ibth),
    .clr_bits  (clr_bits)
  );

  pin_io_detect #(.NPIN(NPIN)) i_detect (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cur       (cur),
    .prv       (prv),
    .sense_lvl (ityp),
    .polarity  (ipol),
    .any_edge  (ibth),
    .enable    (ien),
    .clr_bits  (clr_bits),
    .pend      (pend)
  );

  assign irq = |(pend & ien & ~imsk);
endmodule

// File: rtl/pin_io_chk.sv
module pin_io_chk #(
  parameter int unsigned NPIN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_sel,
  input logic            bus_en,
  input logic            bus_wr,
  input logic [NPIN-1:0] pin_in,
  input logic [NPIN-1:0] pin_out,
  input logic [NPIN-1:0] cur,
  input logic [NPIN-1:0] pend,
  input logic [NPIN-1:0] ien,
  input logic [NPIN-1:0] imsk,
  input logic            irq
);
  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_en && bus_wr) |=> $stable(pin_out));

  // R4
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (cur == $past(pin_in, 2)));

  // R9
  pend_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(ien)) == '0));

  // R10
  mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (imsk == '1) |-> !irq);

  // R10
  no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> !irq);
endmodule

bind pin_io_ctrl pin_io_chk #(.NPIN(NPIN)) i_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .bus_sel (bus_sel),
  .bus_en  (bus_en),
  .bus_wr  (bus_wr),
  .pin_in  (pin_in),
  .pin_out (pin_out),
  .cur     (cur),
  .pend    (pend),
  .ien     (ien),
  .imsk    (imsk),
  .irq     (irq)
);

// File: tb/test_pin_io_ctrl.sv
module test_pin_io_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_en, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [31:0] pin_in, pin_out, pin_oe, pull_en, pull_up;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pin_io_ctrl i_pin_io_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_en(bus_en),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pull_en(pull_en), .pull_up(pull_up), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_en = 1'b0; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic drive_pins(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_pend(input string tag, input logic [31:0] exp);
    logic [31:0] v;
    rd(8'h28, v);
    chk(tag, v, exp);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 64; a += 4) begin
      rd(8'(a), v);
      chk("R1 register reads zero", v, 32'h0);
    end
    chk("R1 pin_out", pin_out, 0);
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 pull_en", pull_en, 0);
    chk("R1 pull_up", pull_up, 0);
    chk("R1 irq", {31'h0, irq}, 0);
  endtask

  task automatic t_out();
    logic [31:0] v;
    wr(8'h00, 32'hA5A5_0F0F);
    chk("R2 pin_out direct", pin_out, 32'hA5A5_0F0F);
    rd(8'h00, v);
    chk("R2 out readback", v, 32'hA5A5_0F0F);
    wr(8'h0C, 32'hFFFF_0000);
    chk("R2 pin_oe", pin_oe, 32'hFFFF_0000);
    wr(8'h20, 32'h0);
    chk("R3 unrelated write keeps pin_out", pin_out, 32'hA5A5_0F0F);
  endtask

  task automatic t_setclr();
    wr(8'h04, 32'h0000_00F0);
    chk("R3 set", pin_out, 32'hA5A5_0FFF);
    wr(8'h08, 32'h0F00_0001);
    chk("R3 clear", pin_out, 32'hA0A5_0FFE);
    wr(8'h04, 32'h0);
    chk("R3 zero set", pin_out, 32'hA0A5_0FFE);
    wr(8'h08, 32'h0);
    chk("R3 zero clear", pin_out, 32'hA0A5_0FFE);
  endtask

  task automatic t_sync();
    logic [31:0] v;
    @(negedge clk);
    pin_in = 32'h1234_5678;
    rd(8'h10, v);
    chk("R4 one edge old", v, 32'h0);
    rd(8'h10, v);
    chk("R4 two edges new", v, 32'h1234_5678);
    drive_pins(32'h0000_0010);
    rd(8'h10, v);
    chk("R4 restore", v, 32'h0000_0010);
  endtask

  task automatic t_config();
    wr(8'h30, 32'h0000_0018);
    wr(8'h34, 32'h0000_0012);
    wr(8'h38, 32'h0000_0004);
    wr(8'h20, 32'h0000_001F);
    wr(8'h2C, 32'hFFFF_FFFF);
    chk_pend("R11 all cleared", 32'h0);
  endtask

  task automatic t_rise();
    drive_pins(pin_in | 32'h1);
    chk_pend("R5 rise sets", 32'h1);
    chk("R10 irq on", {31'h0, irq}, 1);
    wr(8'h2C, 32'h1);
    chk_pend("R11 clear bit0", 32'h0);
    chk("R10 irq off", {31'h0, irq}, 0);
    drive_pins(pin_in & ~32'h1);
    chk_pend("R5 fall ignored", 32'h0);
  endtask

  task automatic t_fall();
    drive_pins(pin_in | 32'h2);
    chk_pend("R6 rise ignored", 32'h0);
    drive_pins(pin_in & ~32'h2);
    chk_pend("R6 fall sets", 32'h2);
    wr(8'h2C, 32'hFFFF_FFFF);
  endtask

  task automatic t_both();
    drive_pins(pin_in | 32'h4);
    chk_pend("R7 rise sets", 32'h4);
    wr(8'h2C, 32'h4);
    drive_pins(pin_in & ~32'h4);
    chk_pend("R7 fall sets", 32'h4);
    wr(8'h2C, 32'h4);
  endtask

  task automatic t_level();
    drive_pins(pin_in | 32'h8);
    chk_pend("R8 high level sets", 32'h8);
    wr(8'h2C, 32'h8);
    chk_pend("R11 event wins over clear", 32'h8);
    drive_pins(pin_in & ~32'h8);
    chk_pend("R8 stays latched", 32'h8);
    wr(8'h2C, 32'h8);
    chk_pend("R8 clear after leaving", 32'h0);
    drive_pins(pin_in & ~32'h10);
    chk_pend("R8 low level sets", 32'h10);
    wr(8'h2C, 32'h10);
    chk_pend("R8 low level reasserts", 32'h10);
    drive_pins(pin_in | 32'h10);
    wr(8'h2C, 32'h10);
    chk_pend("R8 low cleared", 32'h0);
  endtask

  task automatic t_enable();
    drive_pins(pin_in | 32'h20);
    chk_pend("R9 disabled pin no pend", 32'h0);
    chk("R9 irq stays low", {31'h0, irq}, 0);
    drive_pins(pin_in & ~32'h20);
  endtask

  task automatic t_mask();
    wr(8'h24, 32'h1);
    drive_pins(pin_in | 32'h1);
    chk_pend("R10 masked still pends", 32'h1);
    chk("R10 masked irq low", {31'h0, irq}, 0);
    wr(8'h24, 32'h0);
    chk("R10 unmasked irq high", {31'h0, irq}, 1);
  endtask

  task automatic t_partial();
    drive_pins(pin_in | 32'h4);
    chk_pend("R7 second pin pends", 32'h5);
    wr(8'h2C, 32'h1);
    chk_pend("R11 partial clear", 32'h4);
    wr(8'h2C, 32'hFFFF_FFFF);
    drive_pins(pin_in & ~32'h5);
    chk_pend("R7 both-edge fall only pin2", 32'h4);
    wr(8'h2C, 32'hFFFF_FFFF);
    chk_pend("R11 final clear", 32'h0);
  endtask

  task automatic t_misc();
    logic [31:0] v;
    wr(8'h14, 32'h0F0F_0000);
    wr(8'h18, 32'h0000_0003);
    rd(8'h14, v);
    chk("R12 pull enable readback", v, 32'h0F0F_0000);
    chk("R12 pull_en port", pull_en, 32'h0F0F_0000);
    chk("R12 pull_up port", pull_up, 32'h0000_0003);
    rd(8'h1C, v);
    chk("R12 unmapped 0x1C", v, 0);
    rd(8'hFC, v);
    chk("R12 unmapped 0xFC", v, 0);
    rd(8'h04, v);
    chk("R12 set reg reads zero", v, 0);
    rd(8'h2C, v);
    chk("R12 clear reg reads zero", v, 0);
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 0; bus_en = 0; bus_wr = 0;
    bus_addr = 0; bus_wdata = 0; pin_in = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_out();
    t_setclr();
    t_sync();
    t_config();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_enable();
    t_mask();
    t_partial();
    t_misc();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule